// File: doc/BRIEF.md
# DMA Global Control and Interrupt Aggregator

This block is the shared register block of a multi-channel DMA engine. It keeps the controller-wide enable, a software-owned performance mode bit and two sticky error flags. One flag records that any channel has halted and the other that any channel has hit an address error. It also holds a mask register that marks channels as programmable. Each channel reports three kinds of event: transfer done, halt and address error. Any of these sets that channel's bit in a pending word, and the pending word drives a single interrupt line.

Software kicks channels through a doorbell register. Each bit written as one becomes a single-cycle descriptor-fetch pulse to the matching channel. The interrupt service routine clears pending bits by writing the pending register, usually with zero. It clears the error flags by writing the control register back with the two flag bits at zero. A channel event always beats a clear that lands in the same cycle, so no event is lost.

Register offsets (byte addresses on `reg_addr`): control 0x1000, pending 0x1004, doorbell 0x1008, doorbell set 0x100C, programmable mask 0x101C.

Top module: `dma_glob_regs`

## Requirements
- R1: After reset, every register reads zero and `irq` and `fetch_req` are low.
- R2: A write to control (0x1000) loads bit 0 (enable) and bit 31 (performance mode) from the written data. Reading control returns enable at bit 0, address-error flag at bit 2, halt flag at bit 3 and performance mode at bit 31, with all other bits zero.
- R3: A halt event on any channel sets control bit 3, and an address-error event on any channel sets control bit 2. Both flags stay set until software clears them.
- R4: A control write with bit 2 or bit 3 at zero clears that flag. Writing one to a flag bit never sets it. A channel event in the same cycle as a clearing write leaves the flag set.
- R5: A done, halt or address-error event on channel n sets pending bit n (register 0x1004).
- R6: A write to pending keeps only those set bits that are also one in the written data, so writing zero clears all of them.
- R7: A channel event in the same cycle as a pending write leaves that channel's pending bit set.
- R8: `irq` is high exactly when the enable bit is one and at least one pending bit is set.
- R9: A write to doorbell set (0x100C) drives `fetch_req` equal to the written data for exactly the one cycle after the write edge. Zero bits produce no pulse.
- R10: Reads of doorbell (0x1008), doorbell set (0x100C) and unmapped offsets return zero.
- R11: The programmable mask (0x101C) is a full 32-bit read/write register and drives `chan_prog_mask`.
- R12: Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled and holds until the next read.
- R13: Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ch_done | input | NUM_CH | Per-channel transfer-done event |
| ch_halt | input | NUM_CH | Per-channel halt event |
| ch_aerr | input | NUM_CH | Per-channel address-error event |
| fetch_req | output | NUM_CH | Per-channel descriptor-fetch pulse |
| chan_prog_mask | output | 32 | Programmable-channel mask |
| irq | output | 1 | Aggregated interrupt |

## Verification
The bench builds the block with the default 32 channels and a 13-bit offset. This puts channel 31, the top pending bit and bit 31 of the doorbell and mask at the full data width, where a shifted or truncated lane would show. Directed cases cover event-versus-clear collisions on both the pending word and the error flags, and the gating of `irq` by the enable bit. A long random run then mixes sparse events on all three inputs with random pending and control writes and compares every readback against a bench model.

// File: rtl/dmag_pkg.sv
package dmag_pkg;

    localparam logic [15:0] OFF_CTRL  = 16'h1000;
    localparam logic [15:0] OFF_PEND  = 16'h1004;
    localparam logic [15:0] OFF_DBELL = 16'h1008;
    localparam logic [15:0] OFF_DBSET = 16'h100C;
    localparam logic [15:0] OFF_PMASK = 16'h101C;

    localparam int BIT_EN   = 0;
    localparam int BIT_AERR = 2;
    localparam int BIT_HALT = 3;
    localparam int BIT_PERF = 31;

    typedef struct packed {
        logic en;
        logic aerr;
        logic halt;
        logic perf;
    } ctrl_t;

endpackage

// File: rtl/dmag_ctrl.sv
module dmag_ctrl
    import dmag_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr,
    input  logic  wr_en,
    input  logic  wr_perf,
    input  logic  wr_keep_aerr,
    input  logic  wr_keep_halt,
    input  logic  any_aerr,
    input  logic  any_halt,
    output ctrl_t ctrl_q
);

    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            ctrl_d.en   = wr_en;
            ctrl_d.perf = wr_perf;
            ctrl_d.aerr = ctrl_q.aerr & wr_keep_aerr;
            ctrl_d.halt = ctrl_q.halt & wr_keep_halt;
        end
        // channel events take precedence over a clearing write
        if (any_aerr) ctrl_d.aerr = 1'b1;
        if (any_halt) ctrl_d.halt = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.halt && !wr) |=> ctrl_q.halt); // R3
    AST_HALT_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        any_halt |=> ctrl_q.halt); // R4
    AST_AERR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !ctrl_q.aerr && !any_aerr) |=> !ctrl_q.aerr); // R4

endmodule

// File: rtl/dmag_pend.sv
module dmag_pend #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [NUM_CH-1:0] wdata,
    input  logic [NUM_CH-1:0] ev,
    output logic [NUM_CH-1:0] pend_q
);

    typedef struct packed {
        logic [NUM_CH-1:0] pend;
    } pend_state_t;

    pend_state_t st_d;
    pend_state_t st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr) st_d.pend[i] = st_q.pend[i] & wdata[i];
            if (ev[i]) st_d.pend[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_q = st_q.pend;

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((pend_q & $past(ev)) == $past(ev))); // R7
    AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata == '0 && ev == '0) |=> (pend_q == '0)); // R6

endmodule

// File: rtl/dmag_dbell.sv
module dmag_dbell #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [NUM_CH-1:0] wdata,
    output logic [NUM_CH-1:0] fetch_req
);

    typedef struct packed {
        logic [NUM_CH-1:0] req;
    } db_state_t;

    db_state_t st_d;
    db_state_t st_q;

    always_comb begin
        st_d.req = wr ? wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_req = st_q.req;

    AST_DB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> (fetch_req == '0)); // R9
    AST_DB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (fetch_req == $past(wdata))); // R9

endmodule

// File: rtl/dma_glob_regs.sv
module dma_glob_regs
    import dmag_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_CH-1:0] ch_done,
    input  logic [NUM_CH-1:0] ch_halt,
    input  logic [NUM_CH-1:0] ch_aerr,
    output logic [NUM_CH-1:0] fetch_req,
    output logic [31:0]       chan_prog_mask,
    output logic              irq
);

    localparam int DW = 32;
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFF_PEND);
    localparam logic [ADDR_W-1:0] A_DBSET = ADDR_W'(OFF_DBSET);
    localparam logic [ADDR_W-1:0] A_PMASK = ADDR_W'(OFF_PMASK);

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic [DW-1:0] pmask;
    } top_state_t;

    top_state_t st_d;
    top_state_t st_q;

    logic              hit_ctrl, hit_pend, hit_dbset, hit_pmask;
    logic [NUM_CH-1:0] ev_any;
    logic [NUM_CH-1:0] pend_q;
    ctrl_t             ctrl_q;
    logic [DW-1:0]     ctrl_view;

    assign hit_ctrl  = (reg_addr == A_CTRL);
    assign hit_pend  = (reg_addr == A_PEND);
    assign hit_dbset = (reg_addr == A_DBSET);
    assign hit_pmask = (reg_addr == A_PMASK);
    assign ev_any    = ch_done | ch_halt | ch_aerr;

    dmag_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (reg_wr && hit_ctrl),
        .wr_en        (reg_wdata[BIT_EN]),
        .wr_perf      (reg_wdata[BIT_PERF]),
        .wr_keep_aerr (reg_wdata[BIT_AERR]),
        .wr_keep_halt (reg_wdata[BIT_HALT]),
        .any_aerr     (|ch_aerr),
        .any_halt     (|ch_halt),
        .ctrl_q       (ctrl_q)
    );

    dmag_pend #(.NUM_CH(NUM_CH)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr && hit_pend),
        .wdata  (reg_wdata[NUM_CH-1:0]),
        .ev     (ev_any),
        .pend_q (pend_q)
    );

    dmag_dbell #(.NUM_CH(NUM_CH)) u_dbell (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr && hit_dbset),
        .wdata     (reg_wdata[NUM_CH-1:0]),
        .fetch_req (fetch_req)
    );

    always_comb begin
        ctrl_view = '0;
        ctrl_view[BIT_EN]   = ctrl_q.en;
        ctrl_view[BIT_AERR] = ctrl_q.aerr;
        ctrl_view[BIT_HALT] = ctrl_q.halt;
        ctrl_view[BIT_PERF] = ctrl_q.perf;
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr && hit_pmask) st_d.pmask = reg_wdata;
        if (reg_rd) begin
            if (hit_ctrl)       st_d.rdata = ctrl_view;
            else if (hit_pend)  st_d.rdata = DW'(pend_q);
            else if (hit_pmask) st_d.rdata = st_q.pmask;
            else                st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata      = st_q.rdata;
    assign chan_prog_mask = st_q.pmask;
    assign irq            = ctrl_q.en & (|pend_q);

    AST_DBSET_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && hit_dbset) |=> (reg_rdata == '0)); // R10
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0 && ev_any == '0) |=> !irq); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata)); // R12

endmodule

// File: tb/sim_dma_glob_regs.sv
`timescale 1ns/1ps
module sim_dma_glob_regs;

    localparam int NCH = 32;
    localparam int AW  = 13;
    localparam logic [AW-1:0] A_CTRL  = 13'h1000;
    localparam logic [AW-1:0] A_PEND  = 13'h1004;
    localparam logic [AW-1:0] A_DBELL = 13'h1008;
    localparam logic [AW-1:0] A_DBSET = 13'h100C;
    localparam logic [AW-1:0] A_PMASK = 13'h101C;
    localparam logic [AW-1:0] A_HOLE  = 13'h1010;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n;
    logic           reg_wr, reg_rd;
    logic [AW-1:0]  reg_addr;
    logic [31:0]    reg_wdata, reg_rdata;
    logic [NCH-1:0] ch_done, ch_halt, ch_aerr, fetch_req;
    logic [31:0]    chan_prog_mask;
    logic           irq;

    dma_glob_regs #(.NUM_CH(NCH), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ch_done(ch_done), .ch_halt(ch_halt), .ch_aerr(ch_aerr),
        .fetch_req(fetch_req), .chan_prog_mask(chan_prog_mask), .irq(irq)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic ev_pulse(input logic [31:0] dn, input logic [31:0] hl, input logic [31:0] ae);
        ch_done = dn; ch_halt = hl; ch_aerr = ae;
        @(negedge clk);
        ch_done = '0; ch_halt = '0; ch_aerr = '0;
    endtask

    function automatic logic [31:0] m_pend(input logic [31:0] p, input logic wr,
                                           input logic [31:0] wd, input logic [31:0] ev);
        return (wr ? (p & wd) : p) | ev;
    endfunction

    function automatic logic m_flag(input logic f, input logic wr, input logic keep, input logic ev);
        return (wr ? (f & keep) : f) | ev;
    endfunction

    function automatic logic [31:0] m_ctrl(input logic en, input logic ae, input logic hl, input logic pf);
        return {pf, 27'd0, hl, ae, 1'b0, en};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] mp;
        logic me, ma, mh, mf;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        ch_done = '0; ch_halt = '0; ch_aerr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 fetch_req", fetch_req, 0);
        do_read(A_CTRL, r);  chk("R1 ctrl", r, 0);
        do_read(A_PEND, r);  chk("R1 pend", r, 0);
        do_read(A_PMASK, r); chk("R1 pmask", r, 0);

        // R2 control fields; R4 writing ones does not set flags
        do_write(A_CTRL, 32'hFFFF_FFFF);
        do_read(A_CTRL, r); chk("R2 R4 ctrl all-ones write", r, 32'h8000_0001);

        // R11 programmable mask
        do_write(A_PMASK, 32'hA5C3_0F18);
        do_read(A_PMASK, r); chk("R11 pmask read", r, 32'hA5C3_0F18);
        chk("R11 pmask port", chan_prog_mask, 32'hA5C3_0F18);

        // R13 unmapped write ignored; R10 unmapped read zero
        do_write(A_HOLE, 32'h1234_5678);
        do_read(A_PMASK, r); chk("R13 pmask kept", r, 32'hA5C3_0F18);
        do_read(A_CTRL, r);  chk("R13 ctrl kept", r, 32'h8000_0001);
        do_read(A_HOLE, r);  chk("R10 hole read", r, 0);

        // R5 events set pending; R3 flags set
        ev_pulse(32'h0000_0008, 32'h0000_0080, 32'h0010_0000);
        do_read(A_PEND, r); chk("R5 pend", r, 32'h0010_0088);
        do_read(A_CTRL, r); chk("R3 flags", r, 32'h8000_000D);
        chk("R8 irq on", 32'(irq), 1);

        // R8 gating by enable, flags kept by writing ones
        do_write(A_CTRL, 32'h0000_000C);
        chk("R8 irq gated", 32'(irq), 0);
        do_read(A_CTRL, r); chk("R3 flags sticky", r, 32'h0000_000C);
        do_write(A_CTRL, 32'h8000_0001);
        do_read(A_CTRL, r); chk("R4 flags cleared", r, 32'h8000_0001);
        chk("R8 irq back on", 32'(irq), 1);

        // R6 partial and full clear
        do_write(A_PEND, 32'h0000_0008);
        do_read(A_PEND, r); chk("R6 partial clear", r, 32'h0000_0008);
        do_write(A_PEND, 32'h0);
        do_read(A_PEND, r); chk("R6 clear all", r, 0);
        chk("R8 irq off", 32'(irq), 0);

        // R7 event beats clear on channel 31
        ch_done = 32'h8000_0000;
        do_write(A_PEND, 32'h0);
        ch_done = '0;
        do_read(A_PEND, r); chk("R7 event wins", r, 32'h8000_0000);

        // R4 halt event in the same cycle as a clearing control write
        ch_halt = 32'h0000_0002;
        do_write(A_CTRL, 32'h0000_0001);
        ch_halt = '0;
        do_read(A_CTRL, r); chk("R4 event wins flag", r, 32'h0000_0009);
        do_write(A_PEND, 32'h0);

        // R9 doorbell pulse
        reg_wr = 1'b1; reg_addr = A_DBSET; reg_wdata = 32'h8000_8421;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R9 pulse", fetch_req, 32'h8000_8421);
        @(negedge clk);
        chk("R9 one cycle", fetch_req, 0);
        reg_wr = 1'b1; reg_addr = A_DBSET; reg_wdata = 32'h0;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R9 zero write no pulse", fetch_req, 0);

        // R10 doorbell reads zero
        do_read(A_DBSET, r); chk("R10 dbset read", r, 0);
        do_read(A_DBELL, r); chk("R10 dbell read", r, 0);

        // R12 read latency
        reg_rd = 1'b1; reg_addr = A_PMASK;
        #1;
        chk("R12 old data before edge", reg_rdata, 0);
        @(negedge clk);
        reg_rd = 1'b0;
        chk("R12 data after edge", reg_rdata, 32'hA5C3_0F18);
        @(negedge clk);
        chk("R12 data held", reg_rdata, 32'hA5C3_0F18);

        // random phase against the bench model
        do_write(A_CTRL, 32'h0);
        do_write(A_PEND, 32'h0);
        mp = '0; me = 1'b0; ma = 1'b0; mh = 1'b0; mf = 1'b0;
        for (int it = 0; it < 150; it++) begin
            logic [31:0] dn, hl, ae, wd;
            int op;
            dn = $urandom & $urandom & $urandom & $urandom;
            hl = $urandom & $urandom & $urandom & $urandom & $urandom;
            ae = $urandom & $urandom & $urandom & $urandom & $urandom;
            if ($urandom % 3 == 0) begin dn = '0; hl = '0; ae = '0; end
            wd = $urandom;
            if ($urandom % 2 == 0) wd = wd & $urandom;
            op = int'($urandom % 4);
            ch_done = dn; ch_halt = hl; ch_aerr = ae;
            reg_wr = (op < 2); reg_addr = (op == 0) ? A_PEND : A_CTRL; reg_wdata = wd;
            @(negedge clk);
            reg_wr = 1'b0; ch_done = '0; ch_halt = '0; ch_aerr = '0;
            mp = m_pend(mp, op == 0, wd, dn | hl | ae);
            ma = m_flag(ma, op == 1, wd[2], |ae);
            mh = m_flag(mh, op == 1, wd[3], |hl);
            if (op == 1) begin me = wd[0]; mf = wd[31]; end
            chk("R8 irq random", 32'(irq), 32'(me & (|mp)));
            do_read(A_PEND, r); chk("R5 R6 R7 pend random", r, mp);
            do_read(A_CTRL, r); chk("R3 R4 ctrl random", r, m_ctrl(me, ma, mh, mf));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule